// File: doc/BRIEF.md
# Virtual Resource Management Command Engine

This block executes the virtualization-management admin command for a storage controller that shares two kinds of flexible resources, I/O queues and interrupt vectors, between itself (the primary) and a small set of secondary controllers. A command arrives as an opcode and two 32-bit command dwords on a valid/ready port. The engine decodes the fields, validates them against its allocation bookkeeping, updates that bookkeeping and returns a 16-bit completion status, a do-not-retry flag and a 32-bit result one cycle after acceptance.

Each resource kind has its own pool with a fixed total, a pending primary amount, an active primary amount and the sum currently handed to secondaries. A secondary table holds, for each secondary, an online flag and its queue and interrupt counts. Bringing a secondary online or taking it offline also emits a one-cycle request to a separate controller-state block. A function-level reset input makes the pending primary amounts active and returns every secondary to offline with no resources.

Top module: `vrm_cmd_engine`

## Requirements
- R1: Only opcode 0x1C is executed, and any other opcode completes with status 0x001. The action comes from dword10 bits [3:0], the resource type from dword10 bits [10:8], the target controller ID from dword10 bits [31:16] and the count from dword11 bits [15:0]. All other dword bits are ignored.
- R2: The resource type is checked first: 0 selects queues, 1 selects interrupts, and any other type gives 0x122 whatever the action. With a valid type, an action other than 0x1 (primary allocate), 0x7 (offline), 0x8 (assign) or 0x9 (online) gives 0x002.
- R3: Every nonzero status has the do-not-retry flag set. Success is status 0 with the flag clear. The result equals the requested count on a successful allocate or assign and is 0 otherwise.
- R4: Primary allocate gives 0x11F when the target ID differs from the own ID (0). It gives 0x121 when the count exceeds the pool total, and 0x122 when the count exceeds the total minus the secondary-assigned sum. Otherwise the count is stored as pending.
- R5: A pending primary amount does not affect the free amount until the next function-level reset, which makes it active.
- R6: Assign gives 0x11F for an ID not in the table, then 0x120 when the target is online, then 0x121 when the count exceeds the per-secondary maximum of that type (5 queues, 4 interrupts by default).
- R7: For assign, free = total - active primary - secondary-assigned sum. A count minus the target's current count above free gives 0x122. Otherwise the target's count is replaced and the sum moves by the difference.
- R8: Online gives 0x120 unless the target holds at least 2 queues and 1 interrupt. On success it marks the target online, and only an offline-to-online change pulses the state request with online=1 and the table index.
- R9: Offline returns both of the target's counts to their pools and marks it offline. Only an online target produces a state-request pulse with online=0.
- R10: A response appears on the cycle after acceptance and lasts one cycle. Ready is low while it is shown and during function-level reset.
- R11: Function-level reset clears every secondary's counts and online flag and zeroes both secondary-assigned sums.
- R12: Secondary i (0-based) has ID 1+i. IDs outside the configured number of secondaries never match and give 0x11F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flr | input | 1 | Function-level reset pulse |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Engine can take a command |
| req_opcode | input | 8 | Admin opcode |
| req_dw10 | input | 32 | Command dword 10 |
| req_dw11 | input | 32 | Command dword 11 |
| rsp_valid | output | 1 | Completion present for one cycle |
| rsp_status | output | 16 | Completion status code |
| rsp_dnr | output | 1 | Do-not-retry flag |
| rsp_result | output | 32 | Completion result |
| st_req_valid | output | 1 | Online/offline request to the state block |
| st_req_online | output | 1 | 1 = bring online, 0 = take offline |
| st_req_index | output | 2 | Secondary table index of the request |

## Verification
The bench drives every resource type code with every action code, which separates the type-first rejection from the action decode. It sweeps primary allocation counts across both pool totals with matching and wrong IDs, which locates the invalid-number and invalid-identifier boundaries. It then sweeps assign counts over every table ID and several IDs outside the table. This runs each pool into its free limit both before and after a function-level reset, which shows whether the pending primary amount takes effect only at the reset. Online and offline sequences, together with repeated assigns to online targets, tell state-change pulses apart from idempotent commands and confirm that released counts return to the pool.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam logic [7:0]  OPC_VMGMT    = 8'h1C;
  localparam logic [3:0]  ACT_PRIM     = 4'h1;
  localparam logic [3:0]  ACT_OFF      = 4'h7;
  localparam logic [3:0]  ACT_ASSIGN   = 4'h8;
  localparam logic [3:0]  ACT_ON       = 4'h9;
  localparam logic [15:0] ST_OK        = 16'h000;
  localparam logic [15:0] ST_BAD_OPC   = 16'h001;
  localparam logic [15:0] ST_BAD_FIELD = 16'h002;
  localparam logic [15:0] ST_BAD_CID   = 16'h11F;
  localparam logic [15:0] ST_BAD_STATE = 16'h120;
  localparam logic [15:0] ST_BAD_NUM   = 16'h121;
  localparam logic [15:0] ST_BAD_RID   = 16'h122;

  typedef struct packed {
    logic [3:0]  act;
    logic [2:0]  rtype;
    logic [15:0] cid;
    logic [15:0] nr;
  } vrm_cmd_t;
endpackage

// File: rtl/vrm_decode.sv
module vrm_decode
  import vrm_pkg::*;
(
  input  logic [31:0] dw10,
  input  logic [31:0] dw11,
  output vrm_cmd_t    cmd
);
  logic unused_bits;
  assign unused_bits = ^{dw10[15:11], dw10[7:4], dw11[31:16]};

  // R1: field positions
  assign cmd.act   = dw10[3:0];
  assign cmd.rtype = dw10[10:8];
  assign cmd.cid   = dw10[31:16];
  assign cmd.nr    = dw11[15:0];
endmodule

// File: rtl/vrm_sec_lookup.sv
module vrm_sec_lookup #(
  parameter int NUM_SEC     = 4,
  parameter int SEC_ID_BASE = 1,
  parameter int IW          = 2
) (
  input  logic [15:0]   cid,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [NUM_SEC-1:0] match;

  generate
    for (genvar i = 0; i < NUM_SEC; i++) begin : g_cmp
      assign match[i] = (cid == 16'(SEC_ID_BASE + i));
    end
  endgenerate

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = NUM_SEC - 1; i >= 0; i--)
      if (match[i]) idx = IW'(i);
  end

  // R12: at most one table entry can claim an ID
  always_comb a_r12_single_match: assert ($onehot0(match));
endmodule

// File: rtl/vrm_pool.sv
module vrm_pool #(
  parameter int TOTAL = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flr,
  input  logic [15:0] nr,
  input  logic [15:0] cur,
  input  logic        set_pend,
  input  logic        upd_sec,
  input  logic [15:0] new_cnt,
  output logic        ok_total,
  output logic        ok_unassigned,
  output logic        ok_free
);
  localparam int AW = 20;
  localparam int SW = AW + 2;

  logic [AW-1:0] pend_r, act_r, sec_r;
  logic signed [SW-1:0] free_s, diff_s, unas_s;

  assign free_s = $signed(SW'(TOTAL)) - $signed(SW'(act_r)) - $signed(SW'(sec_r));
  assign unas_s = $signed(SW'(TOTAL)) - $signed(SW'(sec_r));
  assign diff_s = $signed(SW'(nr)) - $signed(SW'(cur));

  assign ok_total      = (SW'(nr) <= SW'(TOTAL));
  assign ok_unassigned = ($signed(SW'(nr)) <= unas_s);
  assign ok_free       = (diff_s <= free_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_r <= '0;
      act_r  <= '0;
      sec_r  <= '0;
    end else if (flr) begin
      act_r <= pend_r;
      sec_r <= '0;
    end else begin
      if (set_pend) pend_r <= AW'(nr);
      if (upd_sec)  sec_r  <= sec_r + AW'(new_cnt) - AW'(cur);
    end
  end

  // R7: the pool is never over-committed
  a_r7_pool_bound: assert property (@(posedge clk) disable iff (rst)
    (SW'(act_r) + SW'(sec_r)) <= SW'(TOTAL));
  // R5: the active primary amount moves only at function-level reset
  a_r5_active_hold: assert property (@(posedge clk) disable iff (rst)
    !flr |=> $stable(act_r));
endmodule

// File: rtl/vrm_cmd_engine.sv
module vrm_cmd_engine
  import vrm_pkg::*;
#(
  parameter int NUM_SEC     = 4,
  parameter int CTRL_ID     = 0,
  parameter int SEC_ID_BASE = 1,
  parameter int Q_TOTAL     = 16,
  parameter int I_TOTAL     = 12,
  parameter int Q_SEC_MAX   = 5,
  parameter int I_SEC_MAX   = 4,
  localparam int IW = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [7:0]    req_opcode,
  input  logic [31:0]   req_dw10,
  input  logic [31:0]   req_dw11,
  output logic          rsp_valid,
  output logic [15:0]   rsp_status,
  output logic          rsp_dnr,
  output logic [31:0]   rsp_result,
  output logic          st_req_valid,
  output logic          st_req_online,
  output logic [IW-1:0] st_req_index
);
  vrm_cmd_t cmd;
  logic hit, accept, rsel;
  logic [IW-1:0] idx;
  logic [15:0] q_cnt [NUM_SEC];
  logic [15:0] i_cnt [NUM_SEC];
  logic [NUM_SEC-1:0] sec_on;
  logic [15:0] cur_q, cur_i, smax_sel;
  logic [1:0] ok_total, ok_unas, ok_free;
  logic [15:0] nx_status;
  logic [31:0] nx_result;
  logic do_prim, do_assign, do_on, do_off;

  vrm_decode u_dec (.dw10(req_dw10), .dw11(req_dw11), .cmd(cmd));

  vrm_sec_lookup #(.NUM_SEC(NUM_SEC), .SEC_ID_BASE(SEC_ID_BASE), .IW(IW)) u_lookup (
    .cid(cmd.cid), .hit(hit), .idx(idx));

  assign req_ready = !rsp_valid && !flr;
  assign accept    = req_valid && req_ready;
  assign rsel      = cmd.rtype[0];
  assign cur_q     = q_cnt[idx];
  assign cur_i     = i_cnt[idx];
  assign smax_sel  = rsel ? 16'(I_SEC_MAX) : 16'(Q_SEC_MAX);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_pool
      vrm_pool #(.TOTAL((g == 1) ? I_TOTAL : Q_TOTAL)) u_pool (
        .clk(clk), .rst(rst), .flr(flr),
        .nr(cmd.nr),
        .cur((g == 1) ? cur_i : cur_q),
        .set_pend(accept && do_prim && (rsel == 1'(g))),
        .upd_sec(accept && ((do_assign && (rsel == 1'(g))) || do_off)),
        .new_cnt(do_off ? 16'd0 : cmd.nr),
        .ok_total(ok_total[g]),
        .ok_unassigned(ok_unas[g]),
        .ok_free(ok_free[g]));
    end
  endgenerate

  always_comb begin
    nx_status = ST_OK;
    nx_result = '0;
    do_prim   = 1'b0;
    do_assign = 1'b0;
    do_on     = 1'b0;
    do_off    = 1'b0;
    if (req_opcode != OPC_VMGMT)      nx_status = ST_BAD_OPC;
    else if (cmd.rtype > 3'd1)        nx_status = ST_BAD_RID;
    else begin
      case (cmd.act)
        ACT_PRIM: begin
          if (cmd.cid != 16'(CTRL_ID)) nx_status = ST_BAD_CID;
          else if (!ok_total[rsel])    nx_status = ST_BAD_NUM;
          else if (!ok_unas[rsel])     nx_status = ST_BAD_RID;
          else begin do_prim = 1'b1; nx_result = {16'h0, cmd.nr}; end
        end
        ACT_ASSIGN: begin
          if (!hit)                    nx_status = ST_BAD_CID;
          else if (sec_on[idx])        nx_status = ST_BAD_STATE;
          else if (cmd.nr > smax_sel)  nx_status = ST_BAD_NUM;
          else if (!ok_free[rsel])     nx_status = ST_BAD_RID;
          else begin do_assign = 1'b1; nx_result = {16'h0, cmd.nr}; end
        end
        ACT_ON: begin
          if (!hit)                              nx_status = ST_BAD_CID;
          else if (cur_i == 16'd0 || cur_q < 16'd2) nx_status = ST_BAD_STATE;
          else                                   do_on = 1'b1;
        end
        ACT_OFF: begin
          if (!hit) nx_status = ST_BAD_CID;
          else      do_off = 1'b1;
        end
        default: nx_status = ST_BAD_FIELD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flr) begin
      rsp_valid     <= 1'b0;
      rsp_status    <= '0;
      rsp_dnr       <= 1'b0;
      rsp_result    <= '0;
      st_req_valid  <= 1'b0;
      st_req_online <= 1'b0;
      st_req_index  <= '0;
      sec_on        <= '0;
      for (int i = 0; i < NUM_SEC; i++) begin
        q_cnt[i] <= '0;
        i_cnt[i] <= '0;
      end
    end else begin
      rsp_valid    <= accept;
      st_req_valid <= 1'b0;
      if (accept) begin
        rsp_status <= nx_status;
        rsp_dnr    <= (nx_status != ST_OK);
        rsp_result <= nx_result;
        if (do_assign) begin
          if (rsel) i_cnt[idx] <= cmd.nr;
          else      q_cnt[idx] <= cmd.nr;
        end
        if (do_on && !sec_on[idx]) begin
          sec_on[idx]   <= 1'b1;
          st_req_valid  <= 1'b1;
          st_req_online <= 1'b1;
          st_req_index  <= idx;
        end
        if (do_off) begin
          q_cnt[idx] <= '0;
          i_cnt[idx] <= '0;
          if (sec_on[idx]) begin
            sec_on[idx]   <= 1'b0;
            st_req_valid  <= 1'b1;
            st_req_online <= 1'b0;
            st_req_index  <= idx;
          end
        end
      end
    end
  end

  a_r10_ready_low: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);
  a_r10_rsp_follows_accept: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready));
  a_r3_error_dnr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != ST_OK) |-> rsp_dnr);
  a_r8_state_req_on_success: assert property (@(posedge clk) disable iff (rst)
    st_req_valid |-> (rsp_valid && rsp_status == ST_OK));
  a_r8_online_has_resources: assert property (@(posedge clk) disable iff (rst)
    (st_req_valid && st_req_online) |->
      (q_cnt[st_req_index] >= 16'd2 && i_cnt[st_req_index] != 16'd0));
  a_r11_flr_offline: assert property (@(posedge clk) disable iff (rst)
    flr |=> (sec_on == '0));
endmodule

// File: tb/test_vrm_cmd_engine.sv
`timescale 1ns/1ps
module test_vrm_cmd_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flr = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_opcode = 8'h1C;
  logic [31:0] req_dw10 = '0;
  logic [31:0] req_dw11 = '0;
  logic rsp_valid, rsp_dnr, st_req_valid, st_req_online;
  logic [15:0] rsp_status;
  logic [31:0] rsp_result;
  logic [1:0] st_req_index;

  int tests = 0;
  int fails = 0;

  // bench-side bookkeeping of the allocation state
  int tot[2]  = '{16, 12};
  int smax[2] = '{5, 4};
  int pend[2] = '{0, 0};
  int actv[2] = '{0, 0};
  int secs[2] = '{0, 0};
  int cnt[4][2];
  int on[4];

  always #10 clk = ~clk;

  vrm_cmd_engine i_vrm_cmd_engine (
    .clk(clk), .rst(rst), .flr(flr),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_dw10(req_dw10), .req_dw11(req_dw11),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_dnr(rsp_dnr),
    .rsp_result(rsp_result), .st_req_valid(st_req_valid),
    .st_req_online(st_req_online), .st_req_index(st_req_index));

  task automatic check(input bit ok, input string tag, input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic model(input int op, input int act, input int rt, input int cid,
                       input int n, output int est, output int eres,
                       output int sv, output int son, output int sidx);
    int k;
    bit hit;
    est = 0; eres = 0; sv = 0; son = 0; sidx = 0;
    k = cid - 1;
    hit = (cid >= 1 && cid <= 4);
    if (op != 'h1C) est = 'h001;
    else if (rt > 1) est = 'h122;
    else if (act == 1) begin
      if (cid != 0) est = 'h11F;
      else if (n > tot[rt]) est = 'h121;
      else if (n > tot[rt] - secs[rt]) est = 'h122;
      else begin pend[rt] = n; eres = n; end
    end else if (act == 8) begin
      if (!hit) est = 'h11F;
      else if (on[k] != 0) est = 'h120;
      else if (n > smax[rt]) est = 'h121;
      else if (n - cnt[k][rt] > tot[rt] - actv[rt] - secs[rt]) est = 'h122;
      else begin
        secs[rt] = secs[rt] + n - cnt[k][rt];
        cnt[k][rt] = n;
        eres = n;
      end
    end else if (act == 9) begin
      if (!hit) est = 'h11F;
      else if (cnt[k][1] == 0 || cnt[k][0] < 2) est = 'h120;
      else if (on[k] == 0) begin on[k] = 1; sv = 1; son = 1; sidx = k; end
    end else if (act == 7) begin
      if (!hit) est = 'h11F;
      else begin
        for (int r = 0; r < 2; r++) begin
          secs[r] = secs[r] - cnt[k][r];
          cnt[k][r] = 0;
        end
        if (on[k] != 0) begin on[k] = 0; sv = 1; son = 0; sidx = k; end
      end
    end else est = 'h002;
  endtask

  task automatic issue(input int op, input int act, input int rt, input int cid,
                       input int n, input string tag);
    int est, eres, sv, son, sidx;
    bit ok;
    model(op, act, rt, cid, n, est, eres, sv, son, sidx);
    @(negedge clk);
    req_opcode = 8'(op);
    req_dw10 = {16'(cid), 5'h0, 3'(rt), 4'h6, 4'(act)};
    req_dw11 = {16'hA5C3, 16'(n)};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ok = rsp_valid && rsp_status == 16'(est) && rsp_dnr == (est != 0) &&
         rsp_result == 32'(eres) && st_req_valid == sv[0] &&
         (sv == 0 || (st_req_online == son[0] && st_req_index == 2'(sidx)));
    check(ok, tag, $sformatf(
      "op %0h act %0h rt %0d cid %0d n %0d: actual v%b st %h dnr %b res %0d sreq %b/%b/%0d, expected st %h dnr %b res %0d sreq %0d/%0d/%0d",
      op, act, rt, cid, n, rsp_valid, rsp_status, rsp_dnr, rsp_result,
      st_req_valid, st_req_online, st_req_index, est[15:0], est != 0, eres, sv, son, sidx));
    @(negedge clk);
    check(!rsp_valid && req_ready, "R10", $sformatf(
      "after response actual valid %b ready %b, expected 0 1", rsp_valid, req_ready));
  endtask

  task automatic pulse_flr();
    @(negedge clk);
    flr = 1'b1;
    @(negedge clk);
    check(!req_ready, "R10", $sformatf("ready during reset pulse actual %b expected 0", req_ready));
    flr = 1'b0;
    for (int r = 0; r < 2; r++) begin
      actv[r] = pend[r];
      secs[r] = 0;
    end
    for (int k = 0; k < 4; k++) begin
      on[k] = 0;
      cnt[k][0] = 0;
      cnt[k][1] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R10: watchdog expired, actual still running, expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin on[k] = 0; cnt[k][0] = 0; cnt[k][1] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !st_req_valid, "R10", $sformatf(
      "reset state actual ready %b valid %b sreq %b, expected 1 0 0", req_ready, rsp_valid, st_req_valid));

    // R1: opcode filter and ignored dword bits
    issue('h06, 1, 0, 0, 3, "R1");
    issue('h1D, 8, 0, 1, 1, "R1");
    // R2: type checked before action, then action decode
    for (int rt = 0; rt < 8; rt++) issue('h1C, 1, rt, 0, 2, "R2");
    for (int rt = 2; rt < 8; rt++) issue('h1C, 3, rt, 0, 2, "R2");
    for (int a = 0; a < 16; a++)
      if (a != 1 && a != 7 && a != 8 && a != 9) issue('h1C, a, 0, 0, 1, "R2");
    // R3: error flags on a plain rejection
    issue('h1C, 9, 0, 7, 0, "R3");
    // R4: primary allocate sweep
    for (int rt = 0; rt < 2; rt++)
      for (int c = 0; c < 2; c++)
        for (int n = 0; n < 18; n++) issue('h1C, 1, rt, c, n, "R4");
    issue('h1C, 1, 0, 0, 4, "R4");
    issue('h1C, 1, 1, 0, 3, "R4");
    // R5: pending primary not yet active, full pool free
    issue('h1C, 8, 0, 1, 5, "R5");
    // R6/R7/R12: assign sweep across IDs in and out of the table
    for (int c = 0; c < 8; c++)
      for (int rt = 0; rt < 2; rt++)
        for (int n = 0; n < 7; n++) issue('h1C, 8, rt, c, n, "R7");
    issue('h1C, 8, 0, 5, 1, "R12");
    issue('h1C, 8, 0, 16'hFFFF, 1, "R12");
    // R4: primary limited by secondary-assigned sum
    issue('h1C, 1, 0, 0, 16, "R4");
    issue('h1C, 1, 0, 0, 4, "R4");
    // R8: online transitions
    for (int c = 1; c < 6; c++) issue('h1C, 9, 0, c, 0, "R8");
    issue('h1C, 9, 1, 1, 0, "R8");
    issue('h1C, 8, 0, 1, 2, "R6");
    issue('h1C, 8, 1, 2, 1, "R6");
    // R9: offline releases and pulses only from online
    issue('h1C, 7, 0, 2, 0, "R9");
    issue('h1C, 7, 0, 2, 0, "R9");
    issue('h1C, 8, 0, 2, 5, "R9");
    issue('h1C, 7, 1, 3, 0, "R9");
    // R11: function-level reset
    pulse_flr();
    issue('h1C, 9, 0, 1, 0, "R11");
    issue('h1C, 7, 0, 1, 0, "R11");
    // R5: active primary now reduces free amount
    for (int c = 1; c < 5; c++)
      for (int rt = 0; rt < 2; rt++)
        for (int n = 6; n >= 0; n--) issue('h1C, 8, rt, c, n, "R5");
    for (int c = 1; c < 5; c++)
      for (int rt = 0; rt < 2; rt++) issue('h1C, 8, rt, c, 5, "R7");
    for (int c = 1; c < 5; c++) issue('h1C, 9, 0, c, 0, "R8");
    for (int c = 1; c < 5; c++) issue('h1C, 7, 0, c, 0, "R9");
    issue('h1C, 8, 0, 4, 5, "R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule